// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clock domains and supply rails of a microcontroller stay alive. It has three modes. In run, everything is enabled. In idle, the CPU clock is gated off while the peripheral and watchdog clocks keep running. In power-down, the CPU, peripheral and watchdog clocks are all stopped. In that mode the real-time clock and oscillator keep-alive, and the main regulator, follow configuration bits captured at the moment of entry.

The CPU enters idle or power-down through one-cycle strobes decoded from the corresponding instructions. Idle ends on an ordinary interrupt request or on a failed peripheral event controller (PEC) transfer. A request serviced as a PEC transfer leaves the CPU asleep. Power-down is either protected, which only reset ends, or interruptible. In the interruptible variant an external wake input turns the main regulator back on. The block then waits a programmable number of stabilization cycles, restores the clocks and pulses a wake-up indication to the CPU.

All outputs are registered and change on the clock edge that samples the causing input. Reset is synchronous and active high.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to run. After that edge `mode` is 2'b00, all five enables are 1 and `wake_pulse` is 0.
- R2: In run, `idle_req` moves the block to idle on the same edge, with `mode`=2'b01, `cpu_clk_en`=0 and `per_clk_en`, `wdt_clk_en`, `rtc_osc_en`, `main_reg_en` all 1. If `idle_req` and `pdown_req` are high together, idle wins.
- R3: In idle, `irq` with `irq_is_pec`=0 returns the block to run on that edge with all clocks on. `wake_pulse` is then 1 for exactly one cycle.
- R4: In idle, `irq` with `irq_is_pec`=1 and no `pec_fail` keeps the block in idle with unchanged outputs.
- R5: In idle, `pec_fail` returns the block to run with a one-cycle `wake_pulse`. This holds even when a PEC-flagged `irq` arrives in the same cycle.
- R6: In run, `pdown_req` without `idle_req` enters power-down: `mode`=2'b10 and `cpu_clk_en`, `per_clk_en`, `wdt_clk_en` all 0.
- R7: During power-down, `rtc_osc_en` equals the value of `rtc_en` sampled on the entry edge. Later changes of `rtc_en` have no effect.
- R8: During power-down, `main_reg_en` is the inverse of `vreg_off` sampled on the entry edge.
- R9: If `pd_intr_mode` was 0 on the entry edge (protected), neither `ext_wake` nor `irq` nor `pec_fail` changes any output. Only reset leaves power-down.
- R10: If `pd_intr_mode` was 1 on entry, `ext_wake` sets `main_reg_en` and `rtc_osc_en` to 1 on that edge while the clocks stay off and `mode` stays 2'b10. Exactly `stab_cycles`+1 edges later the block is in run with all clocks on and a one-cycle `wake_pulse`.
- R11: Outside run, `idle_req` and `pdown_req` have no effect on any output.
- R12: In run, `irq`, `irq_is_pec`, `pec_fail` and `ext_wake` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Idle instruction strobe |
| pdown_req | input | 1 | Power-down instruction strobe |
| irq | input | 1 | Interrupt request pending |
| irq_is_pec | input | 1 | The pending request is serviced as a PEC transfer |
| pec_fail | input | 1 | A PEC transfer did not complete |
| ext_wake | input | 1 | External interrupt for interruptible power-down |
| rtc_en | input | 1 | Keep RTC and oscillator alive in power-down |
| vreg_off | input | 1 | Shut the main regulator in power-down |
| pd_intr_mode | input | 1 | 1 selects interruptible power-down, 0 protected |
| stab_cycles | input | STAB_W | Stabilization wait after power-down wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| rtc_osc_en | output | 1 | RTC and main oscillator keep-alive |
| main_reg_en | output | 1 | Main regulator enable |
| wake_pulse | output | 1 | One-cycle wake-up indication to the CPU |
| mode | output | 2 | 00 run, 01 idle, 10 power-down (including stabilization) |

## Verification
Two pairs of events can collide in one cycle. One pair is the idle and power-down strobes together in run. The other is a PEC-flagged interrupt and a PEC failure together in idle. Directed steps drive each pair in the same cycle: the first must land in idle, the second must wake the CPU. Random stimulus also raises these inputs independently at rates high enough that both collisions recur many times. A cycle model in the bench, written from the requirements, judges every output on every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_IDLE = 2'b01,
    ST_PD   = 2'b10,
    ST_WAKE = 2'b11
  } lpm_st_e;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_IDLE = 2'b01;
  localparam logic [1:0] MODE_PD   = 2'b10;
endpackage

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STAB_W-1:0] load_val,
  input  logic              count_en,
  output logic              done
);
  logic [STAB_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (count_en && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // the counter never wraps upward while it is counting down
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && count_en && cnt_q == '0) |=> cnt_q == '0); // R10
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    idle_req,
  input  logic    pdown_req,
  input  logic    irq,
  input  logic    irq_is_pec,
  input  logic    pec_fail,
  input  logic    ext_wake,
  input  logic    rtc_en,
  input  logic    vreg_off,
  input  logic    pd_intr_mode,
  input  logic    stab_done,
  output lpm_st_e st_q,
  output lpm_st_e st_nxt,
  output logic    rtc_keep_nxt,
  output logic    reg_off_nxt,
  output logic    stab_load,
  output logic    stab_count,
  output logic    wake_q
);
  logic rtc_keep_q, reg_off_q, intr_q, intr_nxt, wake_nxt;

  always_comb begin
    st_nxt       = st_q;
    rtc_keep_nxt = rtc_keep_q;
    reg_off_nxt  = reg_off_q;
    intr_nxt     = intr_q;
    stab_load    = 1'b0;
    wake_nxt     = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (idle_req) begin
          st_nxt = ST_IDLE;
        end else if (pdown_req) begin
          st_nxt       = ST_PD;
          rtc_keep_nxt = rtc_en;
          reg_off_nxt  = vreg_off;
          intr_nxt     = pd_intr_mode;
        end
      end
      ST_IDLE: begin
        if (pec_fail || (irq && !irq_is_pec)) begin
          st_nxt   = ST_RUN;
          wake_nxt = 1'b1;
        end
      end
      ST_PD: begin
        if (intr_q && ext_wake) begin
          st_nxt    = ST_WAKE;
          stab_load = 1'b1;
        end
      end
      ST_WAKE: begin
        if (stab_done) begin
          st_nxt   = ST_RUN;
          wake_nxt = 1'b1;
        end
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  assign stab_count = (st_q == ST_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_RUN;
      rtc_keep_q <= 1'b1;
      reg_off_q  <= 1'b0;
      intr_q     <= 1'b0;
      wake_q     <= 1'b0;
    end else begin
      st_q       <= st_nxt;
      rtc_keep_q <= rtc_keep_nxt;
      reg_off_q  <= reg_off_nxt;
      intr_q     <= intr_nxt;
      wake_q     <= wake_nxt;
    end
  end

  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && irq && !irq_is_pec) |=> (st_q == ST_RUN && wake_q)); // R3
  AST_PEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && irq && irq_is_pec && !pec_fail) |=> st_q == ST_IDLE); // R4
  AST_PEC_FAIL_WAKE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && pec_fail) |=> (st_q == ST_RUN && wake_q)); // R5
  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PD && !intr_q) |=> st_q == ST_PD); // R9
  AST_STROBE_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PD && idle_req) |=> st_q != ST_IDLE); // R11
endmodule

// File: rtl/lpm_out_regs.sv
module lpm_out_regs
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lpm_st_e    st_nxt,
  input  logic       rtc_keep_nxt,
  input  logic       reg_off_nxt,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       wdt_clk_en,
  output logic       rtc_osc_en,
  output logic       main_reg_en,
  output logic [1:0] mode
);
  logic       awake_nxt;
  logic [1:0] mode_nxt;

  always_comb begin
    awake_nxt = (st_nxt == ST_RUN) || (st_nxt == ST_IDLE);
    unique case (st_nxt)
      ST_RUN:  mode_nxt = MODE_RUN;
      ST_IDLE: mode_nxt = MODE_IDLE;
      default: mode_nxt = MODE_PD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en  <= 1'b1;
      per_clk_en  <= 1'b1;
      wdt_clk_en  <= 1'b1;
      rtc_osc_en  <= 1'b1;
      main_reg_en <= 1'b1;
      mode        <= MODE_RUN;
    end else begin
      cpu_clk_en  <= (st_nxt == ST_RUN);
      per_clk_en  <= awake_nxt;
      wdt_clk_en  <= awake_nxt;
      rtc_osc_en  <= (st_nxt == ST_PD) ? rtc_keep_nxt : 1'b1;
      main_reg_en <= (st_nxt == ST_PD) ? !reg_off_nxt : 1'b1;
      mode        <= mode_nxt;
    end
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic              pdown_req,
  input  logic              irq,
  input  logic              irq_is_pec,
  input  logic              pec_fail,
  input  logic              ext_wake,
  input  logic              rtc_en,
  input  logic              vreg_off,
  input  logic              pd_intr_mode,
  input  logic [STAB_W-1:0] stab_cycles,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              wdt_clk_en,
  output logic              rtc_osc_en,
  output logic              main_reg_en,
  output logic              wake_pulse,
  output logic [1:0]        mode
);
  lpm_st_e st_q, st_nxt;
  logic    rtc_keep_nxt, reg_off_nxt, stab_load, stab_count, stab_done;

  lpm_fsm u_fsm (
    .clk, .rst, .idle_req, .pdown_req, .irq, .irq_is_pec, .pec_fail,
    .ext_wake, .rtc_en, .vreg_off, .pd_intr_mode,
    .stab_done, .st_q, .st_nxt, .rtc_keep_nxt, .reg_off_nxt,
    .stab_load, .stab_count, .wake_q(wake_pulse)
  );

  lpm_stab_timer #(.STAB_W(STAB_W)) u_timer (
    .clk, .rst, .load(stab_load), .load_val(stab_cycles),
    .count_en(stab_count), .done(stab_done)
  );

  lpm_out_regs u_out (
    .clk, .rst, .st_nxt, .rtc_keep_nxt, .reg_off_nxt,
    .cpu_clk_en, .per_clk_en, .wdt_clk_en, .rtc_osc_en, .main_reg_en, .mode
  );

  AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PD) |-> (!cpu_clk_en && !per_clk_en && !wdt_clk_en)); // R6
  AST_WAKE_REG_ON: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAKE) |-> (main_reg_en && !cpu_clk_en)); // R10
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R3
  AST_IDLE_CPU_OFF: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (!cpu_clk_en && per_clk_en)); // R2
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
  localparam int SW = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic idle_req = 0, pdown_req = 0, irq = 0, irq_is_pec = 0, pec_fail = 0;
  logic ext_wake = 0, rtc_en = 0, vreg_off = 0, pd_intr_mode = 0;
  logic [SW-1:0] stab_cycles = '0;
  logic cpu_clk_en, per_clk_en, wdt_clk_en, rtc_osc_en, main_reg_en, wake_pulse;
  logic [1:0] mode;
  int errors = 0, checks = 0;

  // model: 0 run, 1 idle, 2 power-down, 3 stabilizing
  int m_st = 0, m_cnt = 0;
  bit m_rtc = 1, m_off = 0, m_intr = 0, m_wake = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  lpm_sequencer #(.STAB_W(SW)) u_lpm_sequencer (.*);

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    m_wake = 0;
    if (rst) begin
      m_st = 0; m_rtc = 1; m_off = 0; m_intr = 0; tag = "R1";
    end else case (m_st)
      0: if (idle_req) begin m_st = 1; tag = "R2"; end
         else if (pdown_req) begin
           m_st = 2; m_rtc = rtc_en; m_off = vreg_off; m_intr = pd_intr_mode; tag = "R6 R7 R8";
         end else tag = "R12";
      1: if (pec_fail) begin m_st = 0; m_wake = 1; tag = "R5"; end
         else if (irq && !irq_is_pec) begin m_st = 0; m_wake = 1; tag = "R3"; end
         else if (irq) tag = "R4";
         else tag = "R11";
      2: if (m_intr && ext_wake) begin m_st = 3; m_cnt = stab_cycles; tag = "R10"; end
         else tag = m_intr ? "R7 R8 R11" : "R9";
      default: begin
         tag = "R10";
         if (m_cnt == 0) begin m_st = 0; m_wake = 1; end
         else m_cnt--;
      end
    endcase
  endtask

  task automatic check_outputs();
    chk(cpu_clk_en, m_st == 0, "cpu_clk_en");
    chk(per_clk_en, m_st <= 1, "per_clk_en");
    chk(wdt_clk_en, m_st <= 1, "wdt_clk_en");
    chk(rtc_osc_en, (m_st == 2) ? m_rtc : 1'b1, "rtc_osc_en");
    chk(main_reg_en, (m_st == 2) ? !m_off : 1'b1, "main_reg_en");
    chk(wake_pulse, m_wake, "wake_pulse");
    checks++;
    if (mode !== ((m_st >= 2) ? 2'b10 : 2'(m_st))) begin
      errors++;
      $display("FAIL %s mode: actual=%b expected=%b", tag, mode, (m_st >= 2) ? 2'b10 : 2'(m_st));
    end
  endtask

  // inputs are set before the call (away from the edge); one edge, then compare
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic quiet();
    idle_req = 0; pdown_req = 0; irq = 0; irq_is_pec = 0; pec_fail = 0; ext_wake = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); rst = 1; step(); rst = 0;       // R1 reset state
    // R2 collision: both strobes in the same cycle, idle wins
    idle_req = 1; pdown_req = 1; step(); quiet();
    // R5 collision: PEC-flagged irq and pec_fail together
    irq = 1; irq_is_pec = 1; pec_fail = 1; step(); quiet(); step();
    // R8 R9 protected power-down with regulator off, RTC on
    rtc_en = 1; vreg_off = 1; pd_intr_mode = 0; pdown_req = 1; step(); quiet();
    rtc_en = 0; ext_wake = 1; irq = 1; idle_req = 1; step(); step(); quiet();
    rst = 1; step(); rst = 0;
    // R10 interruptible wake with zero stabilization
    stab_cycles = 0; pd_intr_mode = 1; vreg_off = 0; rtc_en = 0; pdown_req = 1; step(); quiet();
    ext_wake = 1; step(); quiet(); step(); step();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      rst          = ($urandom_range(299) == 0);
      idle_req     = ($urandom_range(7) == 0);
      pdown_req    = ($urandom_range(9) == 0);
      irq          = ($urandom_range(3) == 0);
      irq_is_pec   = $urandom_range(1);
      pec_fail     = ($urandom_range(11) == 0);
      ext_wake     = ($urandom_range(5) == 0);
      rtc_en       = $urandom_range(1);
      vreg_off     = $urandom_range(1);
      pd_intr_mode = ($urandom_range(3) != 0);
      stab_cycles  = SW'($urandom_range(5));
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule